// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the addresses for a four-word burst to a synchronous memory. A load strobe captures a complete starting address. Every clock edge that sees the active-low advance input asserted moves the burst on by one beat. Only the two low address bits change as the burst moves. The upper bits keep the value captured at load time.

Two orderings are available, and the choice is fixed at load time. Linear ordering counts the low bits upward and wraps modulo four. Interleaved ordering forms the low bits as the starting offset XOR the beat index. Read bursts and write bursts use the same sequencing.

The block drives a registered full address and a registered beat index. The memory controller around it arbitrates the strobes, holds the array and moves the data.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_o` becomes 0 and `beat_o` becomes 0 at that edge.
- R2: `load_i` high at a rising edge sets `addr_o` to `addr_i` and `beat_o` to 0, visible after that edge.
- R3: When `load_i` and an active advance (`adv_n_i` low) occur at the same edge, the load wins. `beat_o` becomes 0 and `addr_o` equals `addr_i`.
- R4: `adv_n_i` low at an edge with no load advances `beat_o` by one, modulo 4.
- R5: `adv_n_i` high at an edge with no load leaves `addr_o` and `beat_o` unchanged.
- R6: With `order_i` = 0 at load (linear), `addr_o[1:0]` equals (start + `beat_o`) mod 4. Here start is `addr_i[1:0]` at load.
- R7: With `order_i` = 1 at load (interleaved), `addr_o[1:0]` equals start XOR `beat_o`.
- R8: `order_i` is sampled only at load. Changing it during a burst does not alter the sequence.
- R9: Bits of `addr_o` above bit 1 change only on a load or a reset.
- R10: Advancing past the fourth beat returns `addr_o` to the starting address, with `beat_o` back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture `addr_i` and `order_i`; start a new burst |
| adv_n_i | input | 1 | Active-low advance to next beat |
| order_i | input | 1 | 0 = linear, 1 = interleaved; used only at load |
| addr_i | input | AW | External starting address |
| addr_o | output | AW | Current burst address (registered) |
| beat_o | output | 2 | Current beat index 0..3 (registered) |

## Verification
The assertions assume that every input has a known value at each rising edge and changes only between edges. They also assume that the order select carries meaning only in the cycle that loads it. The bench changes all inputs on the falling edge. It toggles `order_i` freely in cycles without a load, so any dependence on it outside load shows up. It exercises several starting offsets in each ordering, including bursts that run past four beats and loads issued in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/seq_offset_map.sv
// Maps a starting offset and a beat index to the low address bits.
module seq_offset_map
  import burst_seq_pkg::*;
#(
  parameter int LB = 2
) (
  input  logic [LB-1:0] start_i,
  input  logic [LB-1:0] beat_i,
  input  burst_order_e  order_i,
  output logic [LB-1:0] offset_o
);
  logic [LB-1:0] lin_off;
  logic [LB-1:0] ilv_off;

  // per-bit XOR for interleaved order
  for (genvar b = 0; b < LB; b++) begin : g_ilv
    assign ilv_off[b] = start_i[b] ^ beat_i[b];
  end

  assign lin_off = start_i + beat_i;

  always_comb begin
    if (order_i == ORD_INTERLEAVE) offset_o = ilv_off;
    else                           offset_o = lin_off;
  end
endmodule

// File: rtl/seq_beat_counter.sv
// Beat index register with load-clear and advance.
module seq_beat_counter #(
  parameter int LB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [LB-1:0] beat_q,
  output logic [LB-1:0] beat_next
);
  assign beat_next = beat_q + LB'(1);

  always_ff @(posedge clk) begin
    if (rst)          beat_q <= '0;
    else if (clear_i) beat_q <= '0;
    else if (step_i)  beat_q <= beat_next;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int LB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_n_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic [LB-1:0] beat_o
);
  localparam int UW = AW - LB;

  logic          step;
  logic [LB-1:0] start_q;
  burst_order_e  order_q;
  logic [UW-1:0] upper_q;
  logic [LB-1:0] low_q;
  logic [LB-1:0] beat_next;
  logic [LB-1:0] offset_next;

  assign step = ~adv_n_i & ~load_i;

  seq_beat_counter #(.LB(LB)) u_beat (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (load_i),
    .step_i    (step),
    .beat_q    (beat_o),
    .beat_next (beat_next)
  );

  seq_offset_map #(.LB(LB)) u_map (
    .start_i  (start_q),
    .beat_i   (beat_next),
    .order_i  (order_q),
    .offset_o (offset_next)
  );

  // burst context captured at load
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      order_q <= ORD_LINEAR;
      upper_q <= '0;
    end else if (load_i) begin
      start_q <= addr_i[LB-1:0];
      order_q <= burst_order_e'(order_i);
      upper_q <= addr_i[AW-1:LB];
    end
  end

  // registered low bits
  always_ff @(posedge clk) begin
    if (rst)         low_q <= '0;
    else if (load_i) low_q <= addr_i[LB-1:0];
    else if (step)   low_q <= offset_next;
  end

  assign addr_o = {upper_q, low_q};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 16,
  parameter int LB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          load_i,
  input logic          adv_n_i,
  input logic          order_i,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] addr_o,
  input logic [LB-1:0] beat_o
);
  logic [LB-1:0] c_start;
  logic          c_ilv;
  logic [LB-1:0] c_expect;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_start <= '0;
      c_ilv   <= 1'b0;
    end else if (load_i) begin
      c_start <= addr_i[LB-1:0];
      c_ilv   <= order_i;
    end
  end

  always_comb c_expect = c_ilv ? (c_start ^ beat_o) : LB'(c_start + beat_o);

  a_r1_reset: assert property (@(posedge clk) rst |=> (addr_o == '0 && beat_o == '0));
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(addr_i) && beat_o == '0));
  a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
    (load_i && !adv_n_i) |=> beat_o == '0);
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i) |=> LB'(beat_o - $past(beat_o)) == LB'(1));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(beat_o)));
  // R6, R7, R8: low bits follow the order captured at load
  a_r7_order: assert property (@(posedge clk) disable iff (rst)
    !load_i |-> addr_o[LB-1:0] == c_expect);
  a_r9_upper: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[AW-1:LB] == $past(addr_o[AW-1:LB]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .LB(LB)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
  .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 16;
  localparam int LB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_i = 1'b0;
  logic          adv_n_i = 1'b1;
  logic          order_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [LB-1:0] beat_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int m_addr = 0;
  int m_beat = 0;
  int m_start = 0;
  int m_ilv = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.AW(AW), .LB(LB)) uut (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  task automatic check(input string tag);
    n_chk++;
    if (addr_o !== AW'(m_addr) || beat_o !== LB'(m_beat)) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_o, beat_o, AW'(m_addr), m_beat);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, sample next negedge
  task automatic cyc(input logic ld, input logic advn, input logic ord,
                     input int a, input string tag);
    load_i  = ld;
    adv_n_i = advn;
    order_i = ord;
    addr_i  = AW'(a);
    @(posedge clk);
    if (rst) begin
      m_addr = 0; m_beat = 0; m_start = 0; m_ilv = 0;
    end else if (ld) begin
      m_addr = a; m_beat = 0; m_start = a % 4; m_ilv = ord;
    end else if (!advn) begin
      int low;
      m_beat = (m_beat + 1) % 4;
      low = m_ilv ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
      m_addr = (m_addr & ~3) | low;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1'b1, 1'b0, 1'b1, 16'h5A5B, "R1 reset ignores load");
    rst = 1'b0;
    cyc(1'b0, 1'b1, 1'b0, 0, "R5 idle after reset");
    // linear start 10, run past four beats (wrap)
    cyc(1'b1, 1'b1, 1'b0, 16'h1232, "R2 load linear");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, i[0], 16'hFFFF, "R6 R8 R9 R10 linear step");
    cyc(1'b0, 1'b1, 1'b1, 16'h0000, "R5 hold");
    cyc(1'b0, 1'b1, 1'b0, 16'h0000, "R5 hold");
    // linear start 11
    cyc(1'b1, 1'b1, 1'b0, 16'hABC3, "R2 load linear 11");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1, 0, "R4 R6 R8 linear 11");
    // interleaved start 01 with holds
    cyc(1'b1, 1'b1, 1'b1, 16'h0401, "R2 load interleaved");
    for (int i = 0; i < 6; i++) cyc(1'b0, i[0], ~i[1], 16'h7777, "R7 R8 R5 interleaved 01");
    // interleaved start 10, wrap
    cyc(1'b1, 1'b1, 1'b1, 16'hFFFE, "R2 load interleaved 10");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 0, "R7 R9 R10 interleaved 10");
    // load collides with advance mid-burst
    cyc(1'b1, 1'b0, 1'b0, 16'h3333, "R3 load wins over advance");
    cyc(1'b0, 1'b0, 1'b1, 0, "R4 R6 after collision");
    cyc(1'b1, 1'b0, 1'b1, 16'h8000, "R3 reload mid-burst");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 16'h1111, "R7 R8 interleaved 00");
    rst = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 0, "R1 reset mid-burst");
    rst = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 0, "R4 step from reset");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule